// File: doc/BRIEF.md
# Disturbance-Based Memory Fingerprint Query Sequencer

This block runs one fingerprint measurement against a memory addressed by row and word. A query takes a start row, a count of measurement rows, a hammer mode, two fill bytes and a hammer duration in clock ticks. From these it lays out a region in which hammer rows and measurement rows alternate. It then fills every row of that region with its pattern, switches the refresh-enable output off, and reads word 0 of each hammer row in turn for the whole duration. After that it turns refresh back on and streams every word of the measurement rows out as the result.

The memory port has no stall phase. The sequencer asserts a request only in a cycle where the memory reports ready, and each such cycle is a complete transfer. Read data returns later with a valid strobe. The sequencer counts its outstanding reads and lets all hammer reads drain before it starts the readout, so a late hammer response is never taken as measurement data. The measurement leaves on a valid/ready stream, and a last flag marks the final word of the final row.

Top module: `qs_puf_query`

## Requirements
- R1: After reset, busy is 0, refresh_en is 1, mem_req is 0 and m_valid is 0. Whenever busy is 0, refresh_en is 1 and neither mem_req nor m_valid is asserted.
- R2: With N measurement rows, D = 1 in double-sided mode and D = 0 otherwise, and start row S, each of the rows S to S+2N+D-1 (modulo the row count) is written in all words before refresh drops. Rows at an even offset from S receive the hammer byte and rows at an odd offset receive the measurement byte, with the byte repeated in every byte lane of the word.
- R3: refresh_en is low for exactly max(T,1) consecutive cycles per query, where T is the configured tick count. No write is issued while refresh_en is low.
- R4: While refresh_en is low, every request is a read of word 0 of row S+2i. The index i starts at 0 and steps 0,1,…,H-1,0,… with each issued read. In single-sided mode H = N.
- R5: In double-sided mode H = N+1, so row S+2N is hammered as well.
- R6: The measurement stream carries, in order, words 0 to 2^WORD_W-1 of row S+1, then the same words of row S+3, and so on up to row S+2N-1. Each word holds the memory contents after the hammer window. m_last is 1 only on the final word.
- R7: A start pulse while busy is ignored, and so is a start with a measurement row count of 0. Settings are captured only when a start is accepted.
- R8: mem_req is asserted only in a cycle where mem_ready is 1.
- R9: busy rises in the cycle after an accepted start and falls in the cycle after the last-flagged word is accepted.
- R10: Once m_valid is high and m_ready is low, m_valid stays high and m_data and m_last hold in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch a query (pulse) |
| cfg_start_row | input | ROW_W | First row of the region |
| cfg_puf_rows | input | PC_W | Number of measurement rows (N) |
| cfg_double | input | 1 | 1 = double-sided layout, 0 = single-sided |
| cfg_ham_byte | input | 8 | Fill byte for hammer rows |
| cfg_puf_byte | input | 8 | Fill byte for measurement rows |
| cfg_ticks | input | TICK_W | Refresh-off window length in cycles |
| busy | output | 1 | Query in progress |
| refresh_en | output | 1 | Refresh permitted (low during hammering) |
| mem_req | output | 1 | Memory transfer this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_row | output | ROW_W | Row address |
| mem_word | output | WORD_W | Word address within the row |
| mem_wdata | output | DATA_W | Write data |
| mem_ready | input | 1 | Memory can take a transfer this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DATA_W | Read data |
| m_valid | output | 1 | Measurement word valid |
| m_data | output | DATA_W | Measurement word |
| m_last | output | 1 | Final word of the measurement |
| m_ready | input | 1 | Consumer accepts the word |

## Verification
A wrong row offset or a wrong round-robin index shows up at the very next hammer read as a row that is not S+2i, or as a nonzero word address. A fill-phase counter slip shows up as a wrong write count or a wrong lane byte before refresh drops. A timer off by one changes the refresh-off width, and that is visible as soon as refresh_en comes back high. The bench's memory model alters measurement-row contents at the moment refresh falls. A readout that takes the wrong row, the wrong word or a stale hammer response therefore fails the first streamed word that it corrupts.

// File: rtl/qs_pkg.sv
// Shared types for the fingerprint query sequencer.
package qs_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_FILL,
        PH_HAM,
        PH_DRAIN,
        PH_RDREQ,
        PH_RDWAIT,
        PH_OUT
    } phase_t;
endpackage

// File: rtl/qs_row_map.sv
// Row layout: maps fill offset, hammer index and measurement index to row
// addresses. Even offsets from the base are hammer rows, odd ones measurement
// rows. Assumes ROW_W is at least PC_W+2; addresses wrap modulo 2^ROW_W.
module qs_row_map #(
    parameter int ROW_W = 8,
    parameter int PC_W  = 4,
    localparam int OFF_W = PC_W + 1
) (
    input  logic [ROW_W-1:0] base,
    input  logic [PC_W-1:0]  n_rows,
    input  logic             dbl,
    input  logic [OFF_W-1:0] off,
    input  logic [OFF_W-1:0] h_idx,
    input  logic [PC_W-1:0]  p_idx,
    output logic [ROW_W-1:0] fill_row,
    output logic [ROW_W-1:0] ham_row,
    output logic [ROW_W-1:0] puf_row,
    output logic             fill_is_puf,
    output logic [OFF_W-1:0] total_rows,
    output logic [OFF_W-1:0] ham_rows
);
    // Address arithmetic for the three walkers and the region sizes.
    always_comb begin
        total_rows  = {n_rows, 1'b0} + OFF_W'(dbl);
        ham_rows    = OFF_W'(n_rows) + OFF_W'(dbl);
        fill_row    = base + ROW_W'(off);
        fill_is_puf = off[0];
        ham_row     = base + ROW_W'({h_idx, 1'b0});
        puf_row     = base + ROW_W'({p_idx, 1'b1});
    end
endmodule

// File: rtl/qs_fill_pattern.sv
// Builds a fill word by repeating the selected byte across all lanes.
// Assumes DATA_W is a multiple of 8.
module qs_fill_pattern #(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8
) (
    input  logic              sel_puf,
    input  logic [7:0]        ham_b,
    input  logic [7:0]        puf_b,
    output logic [DATA_W-1:0] word
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // One byte lane of the fill word.
        assign word[g*8 +: 8] = sel_puf ? puf_b : ham_b;
    end
endmodule

// File: rtl/qs_tick_timer.sv
// Window timer: load captures the limit (0 is treated as 1) and clears the
// count; done is high in the last cycle of a run of 'limit' cycles.
module qs_tick_timer #(
    parameter int TICK_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [TICK_W-1:0] ticks,
    input  logic              run,
    output logic              done
);
    logic [TICK_W-1:0] lim_q;
    logic [TICK_W-1:0] cnt_q;

    // Limit capture and elapsed-cycle count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim_q <= TICK_W'(1);
            cnt_q <= '0;
        end else if (load) begin
            lim_q <= (ticks == '0) ? TICK_W'(1) : ticks;
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + TICK_W'(1);
        end
    end

    // Expiry flag for the current cycle.
    assign done = run && (cnt_q >= lim_q - TICK_W'(1));
endmodule

// File: rtl/qs_puf_query.sv
// Query sequencer: fill region, refresh off, hammer word 0 of hammer rows
// round-robin for the configured window, refresh on, drain hammer reads,
// then read and stream every word of the measurement rows.
// Assumes the memory takes a transfer in any cycle where mem_req is high
// (mem_req is only raised while mem_ready is high) and returns read data
// in order, with at most 2^PEND_W-1 reads outstanding.
module qs_puf_query #(
    parameter int ROW_W  = 8,
    parameter int WORD_W = 4,
    parameter int DATA_W = 32,
    parameter int PC_W   = 4,
    parameter int TICK_W = 40,
    parameter int PEND_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ROW_W-1:0]  cfg_start_row,
    input  logic [PC_W-1:0]   cfg_puf_rows,
    input  logic              cfg_double,
    input  logic [7:0]        cfg_ham_byte,
    input  logic [7:0]        cfg_puf_byte,
    input  logic [TICK_W-1:0] cfg_ticks,
    output logic              busy,
    output logic              refresh_en,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ROW_W-1:0]  mem_row,
    output logic [WORD_W-1:0] mem_word,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              m_valid,
    output logic [DATA_W-1:0] m_data,
    output logic              m_last,
    input  logic              m_ready
);
    import qs_pkg::*;

    localparam int OFF_W = PC_W + 1;
    localparam logic [WORD_W-1:0] LAST_WORD = '1;
    localparam logic [PEND_W-1:0] PEND_MAX  = '1;

    phase_t            phase;
    logic [ROW_W-1:0]  s_base;
    logic [PC_W-1:0]   s_n;
    logic              s_dbl;
    logic [7:0]        s_hb, s_pb;
    logic [OFF_W-1:0]  off, h_idx;
    logic [PC_W-1:0]   p_idx;
    logic [WORD_W-1:0] word;
    logic [PEND_W-1:0] pend;
    logic [DATA_W-1:0] data_q;

    logic [ROW_W-1:0]  fill_row, ham_row, puf_row;
    logic              fill_is_puf;
    logic [OFF_W-1:0]  total_rows, ham_rows;
    logic [DATA_W-1:0] fill_word;
    logic              want, t_done, t_load, take_start, out_fire;

    qs_row_map #(.ROW_W(ROW_W), .PC_W(PC_W)) u_map (
        .base(s_base), .n_rows(s_n), .dbl(s_dbl), .off(off), .h_idx(h_idx),
        .p_idx(p_idx), .fill_row(fill_row), .ham_row(ham_row),
        .puf_row(puf_row), .fill_is_puf(fill_is_puf),
        .total_rows(total_rows), .ham_rows(ham_rows)
    );

    qs_fill_pattern #(.DATA_W(DATA_W)) u_pat (
        .sel_puf(fill_is_puf), .ham_b(s_hb), .puf_b(s_pb), .word(fill_word)
    );

    qs_tick_timer #(.TICK_W(TICK_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(t_load), .ticks(cfg_ticks_q),
        .run(phase == PH_HAM), .done(t_done)
    );

    logic [TICK_W-1:0] cfg_ticks_q;

    assign take_start = start && (phase == PH_IDLE) && (cfg_puf_rows != '0);
    assign t_load     = (phase == PH_FILL) && mem_req && (word == LAST_WORD)
                        && (off == total_rows - OFF_W'(1));
    assign out_fire   = (phase == PH_OUT) && m_ready;

    // Port request decode: what the current phase wants to transfer.
    always_comb begin
        want      = 1'b0;
        mem_we    = 1'b0;
        mem_row   = '0;
        mem_word  = '0;
        mem_wdata = '0;
        unique case (phase)
            PH_FILL: begin
                want = 1'b1; mem_we = 1'b1; mem_row = fill_row;
                mem_word = word; mem_wdata = fill_word;
            end
            PH_HAM: begin
                want = (pend != PEND_MAX); mem_row = ham_row;
            end
            PH_RDREQ: begin
                want = 1'b1; mem_row = puf_row; mem_word = word;
            end
            default: ;
        endcase
        mem_req = want && mem_ready;
    end

    // Status and stream outputs derived from the phase register.
    assign busy       = (phase != PH_IDLE);
    assign refresh_en = (phase != PH_HAM);
    assign m_valid    = (phase == PH_OUT);
    assign m_data     = data_q;
    assign m_last     = (phase == PH_OUT) && (word == LAST_WORD)
                        && (p_idx == s_n - PC_W'(1));

    // Count of read responses still owed by the memory.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else pend <= pend + PEND_W'(mem_req && !mem_we) - PEND_W'(mem_rvalid);
    end

    // Phase sequencing, setting capture and walker updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE; s_base <= '0; s_n <= '0; s_dbl <= 1'b0;
            s_hb <= '0; s_pb <= '0; cfg_ticks_q <= '0; off <= '0;
            h_idx <= '0; p_idx <= '0; word <= '0; data_q <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: if (take_start) begin
                    s_base <= cfg_start_row; s_n <= cfg_puf_rows;
                    s_dbl <= cfg_double; s_hb <= cfg_ham_byte;
                    s_pb <= cfg_puf_byte; cfg_ticks_q <= cfg_ticks;
                    off <= '0; h_idx <= '0; p_idx <= '0; word <= '0;
                    phase <= PH_FILL;
                end
                PH_FILL: if (mem_req) begin
                    word <= word + WORD_W'(1);
                    if (word == LAST_WORD) begin
                        off <= off + OFF_W'(1);
                        if (t_load) phase <= PH_HAM;
                    end
                end
                PH_HAM: begin
                    if (mem_req)
                        h_idx <= (h_idx == ham_rows - OFF_W'(1)) ? '0
                                 : h_idx + OFF_W'(1);
                    if (t_done) phase <= PH_DRAIN;
                end
                PH_DRAIN: if (pend == '0) phase <= PH_RDREQ;
                PH_RDREQ: if (mem_req) phase <= PH_RDWAIT;
                PH_RDWAIT: if (mem_rvalid) begin
                    data_q <= mem_rdata;
                    phase  <= PH_OUT;
                end
                PH_OUT: if (out_fire) begin
                    if (m_last) phase <= PH_IDLE;
                    else begin
                        word <= word + WORD_W'(1);
                        if (word == LAST_WORD) p_idx <= p_idx + PC_W'(1);
                        phase <= PH_RDREQ;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/qs_puf_query_chk.sv
// Protocol and phase-ordering checks for qs_puf_query, attached by bind.
module qs_puf_query_chk #(
    parameter int WORD_W = 4,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              refresh_en,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ready,
    input logic [WORD_W-1:0] mem_word,
    input logic              m_valid,
    input logic              m_ready,
    input logic [DATA_W-1:0] m_data,
    input logic              m_last
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (refresh_en && !mem_req && !m_valid));
    // R3
    no_write_refoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !refresh_en |-> !(mem_req && mem_we));
    // R4
    ham_word0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!refresh_en && mem_req) |-> (mem_word == '0));
    // R8
    req_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_ready);
    // R9
    last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_ready && m_last) |=> !busy);
    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));
endmodule

bind qs_puf_query qs_puf_query_chk #(.WORD_W(WORD_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .refresh_en(refresh_en),
    .mem_req(mem_req), .mem_we(mem_we), .mem_ready(mem_ready),
    .mem_word(mem_word), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data), .m_last(m_last)
);

// File: tb/tb_qs_puf_query.sv
module tb_qs_puf_query;
    localparam int ROW_W = 8, WORD_W = 4, DATA_W = 32, PC_W = 4, TICK_W = 40, PEND_W = 3;
    localparam int WORDS = 1 << WORD_W;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [ROW_W-1:0] cfg_start_row = '0;
    logic [PC_W-1:0] cfg_puf_rows = '0;
    logic cfg_double = 1'b0;
    logic [7:0] cfg_ham_byte = '0, cfg_puf_byte = '0;
    logic [TICK_W-1:0] cfg_ticks = '0;
    logic busy, refresh_en, mem_req, mem_we;
    logic [ROW_W-1:0] mem_row;
    logic [WORD_W-1:0] mem_word;
    logic [DATA_W-1:0] mem_wdata, m_data;
    logic mem_ready = 1'b0, mem_rvalid = 1'b0, m_ready = 1'b0;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic m_valid, m_last;

    qs_puf_query #(.ROW_W(ROW_W), .WORD_W(WORD_W), .DATA_W(DATA_W), .PC_W(PC_W),
                   .TICK_W(TICK_W), .PEND_W(PEND_W)) dut (.*);

    always #4 clk = ~clk;   // 125 MHz

    int checks = 0, errors = 0;
    logic [DATA_W-1:0] mem [0:255][0:WORDS-1];
    bit stage_v = 0; logic [DATA_W-1:0] stage_d = '0;
    // current query view held by the bench
    int q_start = 0, q_n = 1, q_dbl = 0, q_ticks = 1;
    logic [7:0] q_hb = 0, q_pb = 0;
    int rdy_pct = 100, out_pct = 100;
    int wr_cnt, refoff, ham_exp, out_idx;
    bit prev_ref = 1, last_pend = 0, saw_last = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] dmask(input int row, input int w);
        return (((row * 7 + w * 3) % 3) == 0) ? (32'h1 << ((row + w) % 32)) : 32'h0;
    endfunction

    function automatic logic [31:0] exp_word(input int idx);
        int row = (q_start + 2 * (idx / WORDS) + 1) % 256;
        return {4{q_pb}} ^ dmask(row, idx % WORDS);
    endfunction

    // Memory and stream-consumer model, one step per falling edge.
    task automatic model_step();
        mem_rvalid = stage_v; mem_rdata = stage_d; stage_v = 0;
        mem_ready = ($urandom % 100) < rdy_pct;
        m_ready   = ($urandom % 100) < out_pct;
        #1;
        if (last_pend) begin
            chk(!busy, "R9 busy after last", busy, 0);
            last_pend = 0;
        end
        if (prev_ref && !refresh_en)    // disturbance applied when refresh drops
            for (int p = 0; p < q_n; p++)
                for (int w = 0; w < WORDS; w++) begin
                    int r = (q_start + 2 * p + 1) % 256;
                    mem[r][w] = mem[r][w] ^ dmask(r, w);
                end
        prev_ref = refresh_en;
        if (!refresh_en) refoff++;
        if (mem_req) begin
            if (mem_we) begin
                logic [7:0] ofs = mem_row - 8'(q_start);
                logic [31:0] e = ofs[0] ? {4{q_pb}} : {4{q_hb}};
                wr_cnt++;
                chk(int'(ofs) < 2 * q_n + q_dbl && mem_wdata == e && refresh_en,
                    "R2 fill write", mem_wdata, e);
                mem[mem_row][mem_word] = mem_wdata;
            end else begin
                stage_v = 1; stage_d = mem[mem_row][mem_word];
                if (!refresh_en) begin
                    int er = (q_start + 2 * ham_exp) % 256;
                    chk(mem_word == 0 && int'(mem_row) == er,
                        q_dbl ? "R5 hammer row" : "R4 hammer row", mem_row, er);
                    ham_exp = (ham_exp == q_n + q_dbl - 1) ? 0 : ham_exp + 1;
                end
            end
        end
        if (m_valid && m_ready) begin
            logic [31:0] e = exp_word(out_idx);
            bit el = (out_idx == q_n * WORDS - 1);
            chk(m_data == e, "R6 measurement word", m_data, e);
            chk(m_last == el, "R6 last flag", m_last, el);
            if (m_last) begin last_pend = 1; saw_last = 1; end
            out_idx++;
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int r = 0; r < 256; r++)
            for (int w = 0; w < WORDS; w++) mem[r][w] = $urandom;
        forever begin
            @(negedge clk);
            model_step();
        end
    end

    task automatic run_query(input int s, input int n, input int dbl, input logic [7:0] hb,
                             input logic [7:0] pb, input int t, input int rp, input int op,
                             input bit inject);
        int guard = 0;
        q_start = s; q_n = n; q_dbl = dbl; q_hb = hb; q_pb = pb; q_ticks = t;
        rdy_pct = rp; out_pct = op;
        wr_cnt = 0; refoff = 0; ham_exp = 0; out_idx = 0; saw_last = 0;
        cfg_start_row = 8'(s); cfg_puf_rows = 4'(n); cfg_double = dbl[0];
        cfg_ham_byte = hb; cfg_puf_byte = pb; cfg_ticks = 40'(t);
        start = 1;
        @(negedge clk); start = 0;
        #2 chk(busy, "R9 busy after start", busy, 1);
        while (busy && guard < 30000) begin
            @(negedge clk); guard++;
            if (inject && guard == 30) begin   // R7: start while busy, other settings
                cfg_start_row = 8'(s + 5); cfg_puf_rows = 4'(n + 1);
                cfg_puf_byte = ~pb; cfg_ticks = 40'(3); start = 1;
            end else start = 0;
        end
        start = 0;
        if (guard >= 30000) chk(0, "watchdog", guard, 0);
        @(negedge clk);
        chk(wr_cnt == (2 * n + dbl) * WORDS, "R2 fill count", wr_cnt, (2 * n + dbl) * WORDS);
        chk(refoff == ((t == 0) ? 1 : t), "R3 refresh-off width", refoff, (t == 0) ? 1 : t);
        chk(out_idx == n * WORDS && saw_last, inject ? "R7 busy start ignored" : "R6 word count",
            out_idx, n * WORDS);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #2;
        chk(!busy && refresh_en && !mem_req && !m_valid, "R1 reset state", busy, 0);
        @(negedge clk); rst_n = 1;
        @(negedge clk); #2;
        chk(!busy && refresh_en && !m_valid, "R1 after reset", busy, 0);
        // R7: zero row count is not accepted
        cfg_puf_rows = '0; start = 1;
        @(negedge clk); start = 0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #2;
            chk(!busy && !mem_req, "R7 zero-count start", busy, 0);
        end
        run_query(10, 2, 0, 8'h55, 8'hAA, 40, 100, 100, 0);   // R4 single-sided
        run_query(20, 2, 1, 8'h55, 8'hAA, 40, 100, 100, 0);   // R5 double-sided
        run_query(30, 1, 0, 8'h00, 8'hFF, 0, 80, 70, 0);      // R3 zero ticks
        run_query(40, 3, 1, 8'h0F, 8'hF0, 1, 60, 50, 0);      // R3 one tick
        run_query(250, 4, 1, 8'h12, 8'h34, 25, 70, 60, 0);    // row wrap
        run_query(100, 15, 0, 8'h55, 8'hAA, 60, 90, 90, 0);   // max rows
        run_query(60, 2, 0, 8'h3C, 8'hC3, 50, 70, 40, 1);     // R7 start while busy
        for (int k = 0; k < 18; k++)
            run_query($urandom % 256, 1 + $urandom % 6, $urandom % 2, 8'($urandom),
                      8'($urandom), 1 + $urandom % 150, 40 + $urandom % 61,
                      30 + $urandom % 71, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule